// File: doc/BRIEF.md
# Segment Relocation and Limit Checker

This block turns effective addresses into physical addresses for a simple segmented memory model. Every request carries an effective address and an access kind: instruction fetch or data load/store. Each kind owns its own pair of registers, an offset that is added to the address and a limit the address must not exceed. A request whose address lies at or below the limit of its kind leaves with a valid physical address one cycle later. A request beyond the limit leaves with a fault flag instead, and no physical address is marked valid, so no memory access may start from it.

The four offset and limit registers change only through a configuration write port. That port accepts a write only while the supervisor-mode input is high. A write attempted in user mode leaves all registers unchanged and raises a one-cycle privilege-error pulse. All registers clear to zero on reset, so until software programs them only effective address zero is reachable, and it maps to physical address zero.

Top module: `bb_xlate`

## Requirements
- R1: After reset all outputs are low and all four registers hold zero: a request for address 0 returns physical address 0 as valid, and any other address faults for either kind.
- R2: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high, and low otherwise.
- R3: When the effective address is at or below the selected limit, `rsp_pa_valid` is high and `rsp_pa` equals the effective address plus the selected offset, modulo 2^ADDR_W.
- R4: When the effective address exceeds the selected limit, `rsp_fault` is high, `rsp_pa_valid` is low and `rsp_pa` is zero; `rsp_fault` and `rsp_pa_valid` are never high together and are both low when `rsp_valid` is low.
- R5: `req_kind` = 1 (fetch) selects the fetch offset and fetch limit; `req_kind` = 0 (data) selects the data offset and data limit; neither pair affects the other kind.
- R6: A write with `cfg_we` and `sup_mode` high stores `cfg_wdata` into the register chosen by `cfg_sel` (0 fetch offset, 1 fetch limit, 2 data offset, 3 data limit); it governs requests from the next cycle on, while a request in the same cycle as the write still uses the previous value.
- R7: A write with `cfg_we` high and `sup_mode` low changes no register, and `priv_err` is high for exactly the following cycle.
- R8: `priv_err` stays low after cycles without a write and after supervisor-mode writes.
- R9: An effective address equal to the limit is translated; the address one above the limit faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 1 | 1 = instruction fetch, 0 = data access |
| req_ea | input | ADDR_W | Effective address |
| sup_mode | input | 1 | Processor is in supervisor mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 fetch offset, 1 fetch limit, 2 data offset, 3 data limit |
| cfg_wdata | input | ADDR_W | Value to write |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_pa_valid | output | 1 | Physical address valid; memory access may start |
| rsp_pa | output | ADDR_W | Physical address, zero when not valid |
| rsp_fault | output | 1 | Limit exceeded |
| priv_err | output | 1 | A user-mode configuration write was refused last cycle |

## Verification
A configuration write and a translation request can share one cycle, and the request then must see the register value from before the write. The bench drives a supervisor write that moves a limit or offset together with a request whose outcome depends on it, checks that the response follows the old value, and then repeats the request to see the new one. The same overlap is run with a refused user-mode write, where both the response and the following response must stay on the old value while the privilege-error pulse appears.

// File: rtl/bb_xlate_pkg.sv
package bb_xlate_pkg;

   // Register select codes on the configuration port
   typedef enum logic [1:0] {
      SEL_FETCH_OFS = 2'd0,
      SEL_FETCH_LIM = 2'd1,
      SEL_DATA_OFS  = 2'd2,
      SEL_DATA_LIM  = 2'd3
   } bb_sel_e;

   // Access kind codes on req_kind
   localparam logic KIND_DATA  = 1'b0;
   localparam logic KIND_FETCH = 1'b1;

   localparam int unsigned NUM_REGS = 4;

endpackage

// File: rtl/bb_priv_gate.sv
module bb_priv_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_we,
   input  logic sup_mode,
   output logic wr_ok,
   output logic priv_err
);

   logic err_q;

   assign wr_ok = cfg_we & sup_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else begin
         err_q <= cfg_we & ~sup_mode;
      end
   end

   assign priv_err = err_q;

endmodule

// File: rtl/bb_seg_regs.sv
module bb_seg_regs
   import bb_xlate_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] fetch_ofs,
   output logic [ADDR_W-1:0] fetch_lim,
   output logic [ADDR_W-1:0] data_ofs,
   output logic [ADDR_W-1:0] data_lim
);

   logic [ADDR_W-1:0] regs [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [1:0] MY_SEL = 2'(g);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            regs[g] <= '0;
         end else if (wr_en && (wr_sel == MY_SEL)) begin
            regs[g] <= wr_data;
         end
      end
   end

   assign fetch_ofs = regs[SEL_FETCH_OFS];
   assign fetch_lim = regs[SEL_FETCH_LIM];
   assign data_ofs  = regs[SEL_DATA_OFS];
   assign data_lim  = regs[SEL_DATA_LIM];

endmodule

// File: rtl/bb_seg_xlate.sv
module bb_seg_xlate
   import bb_xlate_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic              kind,
   input  logic [ADDR_W-1:0] ea,
   input  logic [ADDR_W-1:0] fetch_ofs,
   input  logic [ADDR_W-1:0] fetch_lim,
   input  logic [ADDR_W-1:0] data_ofs,
   input  logic [ADDR_W-1:0] data_lim,
   output logic [ADDR_W-1:0] pa,
   output logic              in_range
);

   if (SHARED_ADDER) begin : g_shared
      // Select the pair first, then one adder and one comparator
      logic [ADDR_W-1:0] ofs_sel;
      logic [ADDR_W-1:0] lim_sel;
      always_comb begin
         ofs_sel = (kind == KIND_FETCH) ? fetch_ofs : data_ofs;
         lim_sel = (kind == KIND_FETCH) ? fetch_lim : data_lim;
      end
      assign pa       = ea + ofs_sel;
      assign in_range = (ea <= lim_sel);
   end else begin : g_split
      // Both pairs evaluated in parallel, kind selects late
      logic [ADDR_W-1:0] pa_f;
      logic [ADDR_W-1:0] pa_d;
      logic              ok_f;
      logic              ok_d;
      always_comb begin
         pa_f = ea + fetch_ofs;
         pa_d = ea + data_ofs;
         ok_f = (ea <= fetch_lim);
         ok_d = (ea <= data_lim);
      end
      assign pa       = (kind == KIND_FETCH) ? pa_f : pa_d;
      assign in_range = (kind == KIND_FETCH) ? ok_f : ok_d;
   end

endmodule

// File: rtl/bb_rsp_stage.sv
module bb_rsp_stage #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              in_range,
   input  logic [ADDR_W-1:0] pa,
   output logic              rsp_valid,
   output logic              rsp_pa_valid,
   output logic [ADDR_W-1:0] rsp_pa,
   output logic              rsp_fault
);

   logic              v_q;
   logic              ok_q;
   logic              flt_q;
   logic [ADDR_W-1:0] pa_q;
   logic              grant;

   assign grant = req_valid & in_range;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         ok_q  <= 1'b0;
         flt_q <= 1'b0;
         pa_q  <= '0;
      end else begin
         v_q   <= req_valid;
         ok_q  <= grant;
         flt_q <= req_valid & ~in_range;
         pa_q  <= grant ? pa : '0;
      end
   end

   assign rsp_valid    = v_q;
   assign rsp_pa_valid = ok_q;
   assign rsp_fault    = flt_q;
   assign rsp_pa       = pa_q;

endmodule

// File: rtl/bb_xlate.sv
module bb_xlate
   import bb_xlate_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter bit          SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_kind,
   input  logic [ADDR_W-1:0] req_ea,
   input  logic              sup_mode,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic              rsp_valid,
   output logic              rsp_pa_valid,
   output logic [ADDR_W-1:0] rsp_pa,
   output logic              rsp_fault,
   output logic              priv_err
);

   if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
      $error("bb_xlate: ADDR_W must lie in 2..64");
   end

   logic              wr_ok;
   logic [ADDR_W-1:0] fetch_ofs;
   logic [ADDR_W-1:0] fetch_lim;
   logic [ADDR_W-1:0] data_ofs;
   logic [ADDR_W-1:0] data_lim;
   logic [ADDR_W-1:0] pa_c;
   logic              in_range_c;

   bb_priv_gate u_priv (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .sup_mode (sup_mode),
      .wr_ok    (wr_ok),
      .priv_err (priv_err)
   );

   bb_seg_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_ok),
      .wr_sel    (cfg_sel),
      .wr_data   (cfg_wdata),
      .fetch_ofs (fetch_ofs),
      .fetch_lim (fetch_lim),
      .data_ofs  (data_ofs),
      .data_lim  (data_lim)
   );

   bb_seg_xlate #(.ADDR_W(ADDR_W), .SHARED_ADDER(SHARED_ADDER)) u_xlate (
      .kind      (req_kind),
      .ea        (req_ea),
      .fetch_ofs (fetch_ofs),
      .fetch_lim (fetch_lim),
      .data_ofs  (data_ofs),
      .data_lim  (data_lim),
      .pa        (pa_c),
      .in_range  (in_range_c)
   );

   bb_rsp_stage #(.ADDR_W(ADDR_W)) u_rsp (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .in_range     (in_range_c),
      .pa           (pa_c),
      .rsp_valid    (rsp_valid),
      .rsp_pa_valid (rsp_pa_valid),
      .rsp_pa       (rsp_pa),
      .rsp_fault    (rsp_fault)
   );

endmodule

// File: rtl/bb_xlate_chk.sv
module bb_xlate_chk #(
   parameter int unsigned ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              sup_mode,
   input logic              cfg_we,
   input logic              rsp_valid,
   input logic              rsp_pa_valid,
   input logic [ADDR_W-1:0] rsp_pa,
   input logic              rsp_fault,
   input logic              priv_err
);

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2
   AST_NO_RSP_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R2
   AST_GRANT_OR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_pa_valid, rsp_fault})); // R4
   AST_FLAGS_NEED_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_pa_valid || rsp_fault) |-> rsp_valid); // R4
   AST_RSP_CLASSIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_pa_valid || rsp_fault)); // R3
   AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_pa_valid |-> (rsp_pa == '0)); // R4
   AST_PRIV_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !sup_mode) |=> priv_err); // R7
   AST_PRIV_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && !sup_mode) |=> !priv_err); // R8

endmodule

bind bb_xlate bb_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .sup_mode     (sup_mode),
   .cfg_we       (cfg_we),
   .rsp_valid    (rsp_valid),
   .rsp_pa_valid (rsp_pa_valid),
   .rsp_pa       (rsp_pa),
   .rsp_fault    (rsp_fault),
   .priv_err     (priv_err)
);

// File: tb/tb_bb_xlate.sv
module tb_bb_xlate;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 6;
   localparam int SPAN       = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_kind = 1'b0;
   logic [AW-1:0] req_ea = '0;
   logic          sup_mode = 1'b0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0;
   logic          rsp_valid;
   logic          rsp_pa_valid;
   logic [AW-1:0] rsp_pa;
   logic          rsp_fault;
   logic          priv_err;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Bench model of the four registers: 0 fetch ofs, 1 fetch lim, 2 data ofs, 3 data lim
   int mreg [4];

   always #(CLK_PERIOD/2) clk = ~clk;

   bb_xlate #(.ADDR_W(AW), .SHARED_ADDER(1'b1)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_kind     (req_kind),
      .req_ea       (req_ea),
      .sup_mode     (sup_mode),
      .cfg_we       (cfg_we),
      .cfg_sel      (cfg_sel),
      .cfg_wdata    (cfg_wdata),
      .rsp_valid    (rsp_valid),
      .rsp_pa_valid (rsp_pa_valid),
      .rsp_pa       (rsp_pa),
      .rsp_fault    (rsp_fault),
      .priv_err     (priv_err)
   );

   task automatic chk(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Expected outcome of a request from the bench register model
   task automatic expect_of(input int kind, input int ea, output int ok, output int pa);
      int ofs;
      int lim;
      ofs = kind ? mreg[0] : mreg[2];
      lim = kind ? mreg[1] : mreg[3];
      ok  = (ea <= lim) ? 1 : 0;
      pa  = ok ? ((ea + ofs) % SPAN) : 0;
   endtask

   // Drive one request and check the response one cycle later
   task automatic do_req(input string tag, input int kind, input int ea);
      int ok;
      int pa;
      expect_of(kind, ea, ok, pa);
      @(negedge clk);
      req_valid = 1'b1;
      req_kind  = kind[0];
      req_ea    = ea[AW-1:0];
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2", int'(rsp_valid), 1, "rsp_valid");
      chk(tag, int'(rsp_pa_valid), ok, $sformatf("pa_valid k=%0d ea=%0d", kind, ea));
      chk(ok ? "R3" : "R4", int'(rsp_pa), pa, $sformatf("pa k=%0d ea=%0d", kind, ea));
      chk("R4", int'(rsp_fault), 1 - ok, $sformatf("fault k=%0d ea=%0d", kind, ea));
   endtask

   task automatic do_wr(input int sel, input int val, input bit sup);
      @(negedge clk);
      cfg_we    = 1'b1;
      cfg_sel   = sel[1:0];
      cfg_wdata = val[AW-1:0];
      sup_mode  = sup;
      @(negedge clk);
      cfg_we   = 1'b0;
      sup_mode = 1'b0;
      if (sup) begin
         mreg[sel] = val;
         chk("R8", int'(priv_err), 0, "priv_err after supervisor write");
      end else begin
         chk("R7", int'(priv_err), 1, "priv_err after user write");
      end
   endtask

   // Sweep every address for both kinds (R5 separation comes from the per-kind model)
   task automatic sweep(input string tag);
      for (int k = 0; k < 2; k++) begin
         for (int e = 0; e < SPAN; e++) begin
            do_req(tag, k, e);
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) mreg[i] = 0;
      repeat (3) @(negedge clk);
      // R1: outputs low during and right after reset
      chk("R1", int'(rsp_valid), 0, "rsp_valid in reset");
      chk("R1", int'(priv_err), 0, "priv_err in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", int'(rsp_valid | rsp_pa_valid | rsp_fault | priv_err), 0, "outputs after reset");
      chk("R1", int'(rsp_pa), 0, "rsp_pa after reset");
      // R1: zero registers, only address 0 reachable
      sweep("R1");
      // R2: no request, no response
      @(negedge clk);
      chk("R2", int'(rsp_valid), 0, "idle rsp_valid");
      chk("R8", int'(priv_err), 0, "idle priv_err");

      // R6: program distinct pairs, R5: sweep both kinds
      do_wr(0, 5, 1'b1);
      do_wr(1, 20, 1'b1);
      do_wr(2, 40, 1'b1);
      do_wr(3, 63, 1'b1);
      sweep("R5");

      // R3: wrap-around offsets
      do_wr(0, 60, 1'b1);
      do_wr(1, 10, 1'b1);
      do_wr(2, 1, 1'b1);
      do_wr(3, 62, 1'b1);
      sweep("R3");

      // R9: limit edges
      do_req("R9", 1, 10);
      do_req("R9", 1, 11);
      do_req("R9", 0, 62);
      do_req("R9", 0, 63);

      // R7: user-mode writes ignored for every register
      for (int s = 0; s < 4; s++) begin
         do_wr(s, 33, 1'b0);
      end
      @(negedge clk);
      chk("R7", int'(priv_err), 0, "priv_err one cycle only");
      do_req("R7", 1, 10);
      do_req("R7", 1, 11);
      do_req("R7", 0, 62);
      do_req("R7", 0, 5);

      // R6: supervisor write in the same cycle as a request uses the old limit
      @(negedge clk);
      req_valid = 1'b1; req_kind = 1'b1; req_ea = 6'd15;
      cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 6'd30; sup_mode = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0; sup_mode = 1'b0;
      chk("R6", int'(rsp_fault), 1, "same-cycle write uses old limit");
      chk("R8", int'(priv_err), 0, "no priv_err on supervisor write");
      mreg[1] = 30;
      do_req("R6", 1, 15);
      do_req("R9", 1, 30);
      do_req("R9", 1, 31);

      // R6 with offset change in same cycle
      @(negedge clk);
      req_valid = 1'b1; req_kind = 1'b0; req_ea = 6'd4;
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 6'd20; sup_mode = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0; sup_mode = 1'b0;
      chk("R6", int'(rsp_pa), 5, "same-cycle write uses old offset");
      mreg[2] = 20;
      do_req("R6", 0, 4);

      // R7: user write overlapping a request; response and next stay old
      @(negedge clk);
      req_valid = 1'b1; req_kind = 1'b0; req_ea = 6'd4;
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_wdata = 6'd50; sup_mode = 1'b0;
      @(negedge clk);
      req_valid = 1'b0; cfg_we = 1'b0;
      chk("R7", int'(rsp_pa), 24, "overlap user write pa");
      chk("R7", int'(priv_err), 1, "overlap user write priv_err");
      do_req("R7", 0, 4);

      // R1: reset again clears the registers
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) mreg[i] = 0;
      do_req("R1", 1, 0);
      do_req("R1", 0, 1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule